// File: doc/BRIEF.md
# Multi-Stage Peak Candidate Selector

This block sits after a cell-search correlator. It reduces the full set of correlation magnitudes to a short ranked list of candidates. A source streams one batch of `(code, lag, magnitude)` samples. All samples of a code arrive back to back, and the last sample of each code is marked. The block stores every magnitude and keeps a running maximum for each code. It then keeps the K codes whose maxima are strongest.

When the batch ends, the block revisits each kept code and re-reads that code's stored magnitudes. It makes up to J picks per code, one per pass. Each pick is the strongest lag that does not sit within two chips of a lag already picked for the same code. Every pick goes into a final sorted list that holds the M best.

The list is then emitted strongest first, one entry per cycle. A one-cycle done pulse follows the last entry and carries the entry count. All lists are cleared after the done pulse, ready for the next batch. The source must not send samples between the end of a batch and the done pulse.

Top module: `peak_sel_top`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `done` are low.
- R2: A code's strength is the largest magnitude among all samples of that code in the batch, whatever its lag.
- R3: The K codes with the largest strength are kept. Equal strengths favour the lower code number, and the order in which codes are streamed has no effect.
- R4: For each kept code, J passes are made. Each pass picks the largest not-yet-excluded magnitude, and equal magnitudes favour the lower lag.
- R5: A lag whose distance to an earlier pick of the same code is 2 or less is never picked. A lag at distance 3 stays eligible.
- R6: The M best of all picks are reported. The ranking is by magnitude descending, then code ascending, then lag ascending. `out_count` equals min(M, K·J) while `done` is high.
- R7: Entries come out on consecutive cycles with `out_valid` high, in the order given by R6. `done` rises on the cycle after the last entry and never coincides with `out_valid`.
- R8: `done` is high for exactly one cycle per batch.
- R9: A new batch after `done` gives results that depend only on that batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_code | input | CODE_W (6) | Code number of the sample |
| in_lag | input | LAG_W (5) | Lag of the sample |
| in_mag | input | MAG_W (12) | Correlation magnitude |
| in_last | input | 1 | Last sample of the current code |
| in_final | input | 1 | Last sample of the batch (with in_last) |
| out_valid | output | 1 | Candidate entry valid |
| out_code | output | CODE_W (6) | Candidate code |
| out_lag | output | LAG_W (5) | Candidate lag |
| out_mag | output | MAG_W (12) | Candidate magnitude |
| out_count | output | clog2(M+1) | Number of emitted entries, valid with done |
| done | output | 1 | One-cycle end-of-results pulse |

## Verification
The bench builds the block with K=4, J=3 and M=6 over the full 64-code by 32-lag space. With these values the code ranking, per-code passes and final trim can all be checked exhaustively against a bench model in a few thousand cycles per batch. M is smaller than K·J, so the final list always drops some picks, which exercises the cut-off rule.

Batch patterns cover several cases:
- code ties under reversed streaming order;
- an all-zero batch in which every comparison is a tie;
- a clustered peak whose neighbours at distances 2 and 3 probe the exclusion edge;
- narrow-range random data with many equal magnitudes.

// File: rtl/peak_sel_pkg.sv
// Shared widths, the candidate record and the ranking rule.
// Assumes code and lag spaces are powers of two.
package peak_sel_pkg;
    localparam int CODE_W = 6;
    localparam int LAG_W  = 5;
    localparam int MAG_W  = 12;

    typedef struct packed {
        logic [MAG_W-1:0]  mag;
        logic [CODE_W-1:0] code;
        logic [LAG_W-1:0]  lag;
    } cand_t;

    // True when a ranks strictly ahead of b: larger mag, then lower code, then lower lag
    function automatic logic ranks_above(cand_t a, cand_t b);
        if (a.mag != b.mag)   return a.mag > b.mag;
        if (a.code != b.code) return a.code < b.code;
        return a.lag < b.lag;
    endfunction
endpackage

// File: rtl/cand_sorter.sv
// Sorted top-DEPTH list kept by insertion: a new item lands ahead of the first
// entry it outranks and shifts the rest down; the tail entry falls off when full.
// Assumes clr and ins_en are never high together.
module cand_sorter
    import peak_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    ins_en,
    input  cand_t                   ins_item,
    output cand_t [DEPTH-1:0]       items,
    output logic  [CNT_W-1:0]       count
);
    logic [DEPTH-1:0] goes_before;

    // Slot-wise position test: empty slots and outranked entries give way
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            goes_before[i] = (CNT_W'(i) >= count) || ranks_above(ins_item, items[i]);
        end
    end

    // Fill count saturates at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                          count <= '0;
        else if (ins_en && count != CNT_W'(DEPTH))  count <= count + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            // Head slot takes the new item whenever it ranks first
            always_ff @(posedge clk) begin
                if (!rst_n || clr)               items[g] <= '0;
                else if (ins_en && goes_before[g]) items[g] <= ins_item;
            end
        end else begin : g_body
            // Body slot takes the new item at its landing point, else shifts down
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    items[g] <= '0;
                end else if (ins_en && goes_before[g]) begin
                    items[g] <= goes_before[g-1] ? items[g-1] : ins_item;
                end
            end
        end
    end
endmodule

// File: rtl/corr_store.sv
// Magnitude memory indexed by {code, lag}: one write port, one combinational read port.
// Assumes every location is written in a batch before it is read.
module corr_store
    import peak_sel_pkg::*;
#(
    parameter int NCODE = 64,
    parameter int NLAG  = 32,
    localparam int AW   = $clog2(NCODE) + $clog2(NLAG)
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [$clog2(NCODE)-1:0]   wr_code,
    input  logic [$clog2(NLAG)-1:0]    wr_lag,
    input  logic [MAG_W-1:0]           wr_mag,
    input  logic [$clog2(NCODE)-1:0]   rd_code,
    input  logic [$clog2(NLAG)-1:0]    rd_lag,
    output logic [MAG_W-1:0]           rd_mag
);
    logic [MAG_W-1:0] mem [NCODE*NLAG];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en) mem[AW'({wr_code, wr_lag})] <= wr_mag;
    end

    // Read port
    assign rd_mag = mem[AW'({rd_code, rd_lag})];
endmodule

// File: rtl/lag_picker.sv
// One code's lag passes: tracks the best non-excluded sample of the pass and
// presents it on the pass's last step; remembers picks for the exclusion zone.
// Assumes lags arrive ascending within a pass and flush marks the code's last pass end.
module lag_picker
    import peak_sel_pkg::*;
#(
    parameter int J    = 3,
    parameter int EXCL = 2,
    localparam int JC_W = $clog2(J + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [LAG_W-1:0] s_lag,
    input  logic [MAG_W-1:0] s_mag,
    input  logic             last,
    input  logic             flush,
    output logic             res_found,
    output logic [LAG_W-1:0] res_lag,
    output logic [MAG_W-1:0] res_mag
);
    logic [J-1:0]             pick_vld;
    logic [J-1:0][LAG_W-1:0]  pick_lag;
    logic [JC_W-1:0]          npick;
    logic                     run_found;
    logic [LAG_W-1:0]         run_lag;
    logic [MAG_W-1:0]         run_mag;
    logic                     excluded;
    logic                     take;

    // Exclusion: sample lies within EXCL chips of an earlier pick
    always_comb begin
        excluded = 1'b0;
        for (int j = 0; j < J; j++) begin
            if (pick_vld[j] &&
                (((s_lag >= pick_lag[j]) ? (s_lag - pick_lag[j]) : (pick_lag[j] - s_lag))
                 <= LAG_W'(EXCL)))
                excluded = 1'b1;
        end
    end

    // Strict compare keeps the lower lag on equal magnitude
    assign take      = step && !excluded && (!run_found || s_mag > run_mag);
    assign res_found = run_found || take;
    assign res_lag   = take ? s_lag : run_lag;
    assign res_mag   = take ? s_mag : run_mag;

    // Running best within the current pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_found <= 1'b0;
            run_lag   <= '0;
            run_mag   <= '0;
        end else if (step) begin
            if (last) begin
                run_found <= 1'b0;
            end else if (take) begin
                run_found <= 1'b1;
                run_lag   <= s_lag;
                run_mag   <= s_mag;
            end
        end
    end

    // Record pass results as picks; clear them when the code is finished
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_vld <= '0;
            pick_lag <= '0;
            npick    <= '0;
        end else if (step && last) begin
            if (flush) begin
                pick_vld <= '0;
                npick    <= '0;
            end else if (res_found && npick < JC_W'(J)) begin
                pick_vld[npick] <= 1'b1;
                pick_lag[npick] <= res_lag;
                npick           <= npick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/peak_sel_top.sv
// Three-level candidate reduction: per-code maxima -> top-K codes -> J separated
// picks per kept code -> top-M overall, emitted strongest first then a done pulse.
// Assumes each code's samples are contiguous and no input arrives between the
// batch end and done.
module peak_sel_top
    import peak_sel_pkg::*;
#(
    parameter int K = 8,
    parameter int J = 3,
    parameter int M = 12,
    localparam int NCODE = 1 << CODE_W,
    localparam int NLAG  = 1 << LAG_W,
    localparam int KC_W  = $clog2(K + 1),
    localparam int JC_W  = $clog2(J + 1),
    localparam int MC_W  = $clog2(M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic [LAG_W-1:0]  in_lag,
    input  logic [MAG_W-1:0]  in_mag,
    input  logic              in_last,
    input  logic              in_final,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic [LAG_W-1:0]  out_lag,
    output logic [MAG_W-1:0]  out_mag,
    output logic [MC_W-1:0]   out_count,
    output logic              done
);
    typedef enum logic [1:0] {ST_COLLECT, ST_SCAN, ST_EMIT, ST_DONE} state_t;

    state_t              state;
    logic                fresh;
    logic [MAG_W-1:0]    run_max;
    logic [MAG_W-1:0]    in_mx;
    logic [KC_W-1:0]     kidx;
    logic [JC_W-1:0]     pidx;
    logic [LAG_W-1:0]    lidx;
    logic [MC_W-1:0]     oidx;
    logic                accept;
    logic                step;
    logic                pass_end;
    logic                clr_lists;
    cand_t [K-1:0]       code_items;
    logic [KC_W-1:0]     kcnt;
    cand_t [M-1:0]       fin_items;
    logic [MC_W-1:0]     mcnt;
    logic [CODE_W-1:0]   scan_code;
    logic [MAG_W-1:0]    rd_mag;
    logic                res_found;
    logic [LAG_W-1:0]    res_lag;
    logic [MAG_W-1:0]    res_mag;

    assign accept    = (state == ST_COLLECT) && in_valid;
    assign step      = (state == ST_SCAN);
    assign pass_end  = step && (&lidx);
    assign clr_lists = (state == ST_DONE);
    assign scan_code = code_items[kidx].code;

    // Running maximum including the current sample
    assign in_mx = (fresh || in_mag > run_max) ? in_mag : run_max;

    corr_store #(.NCODE(NCODE), .NLAG(NLAG)) store_i (
        .clk(clk), .wr_en(accept), .wr_code(in_code), .wr_lag(in_lag), .wr_mag(in_mag),
        .rd_code(scan_code), .rd_lag(lidx), .rd_mag(rd_mag)
    );

    cand_sorter #(.DEPTH(K)) code_rank_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_lists),
        .ins_en(accept && in_last),
        .ins_item('{mag: in_mx, code: in_code, lag: '0}),
        .items(code_items), .count(kcnt)
    );

    lag_picker #(.J(J), .EXCL(2)) picker_i (
        .clk(clk), .rst_n(rst_n), .step(step), .s_lag(lidx), .s_mag(rd_mag),
        .last(&lidx), .flush(pidx == JC_W'(J - 1)),
        .res_found(res_found), .res_lag(res_lag), .res_mag(res_mag)
    );

    cand_sorter #(.DEPTH(M)) final_rank_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_lists),
        .ins_en(pass_end && res_found),
        .ins_item('{mag: res_mag, code: scan_code, lag: res_lag}),
        .items(fin_items), .count(mcnt)
    );

    // Sequencer: collect, per-code passes, emission, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_COLLECT;
            fresh   <= 1'b1;
            run_max <= '0;
            kidx    <= '0;
            pidx    <= '0;
            lidx    <= '0;
            oidx    <= '0;
        end else begin
            case (state)
                ST_COLLECT: if (in_valid) begin
                    fresh   <= in_last;
                    run_max <= in_mx;
                    if (in_last && in_final) begin
                        state <= ST_SCAN;
                        kidx  <= '0;
                        pidx  <= '0;
                        lidx  <= '0;
                    end
                end
                ST_SCAN: begin
                    lidx <= lidx + 1'b1;
                    if (&lidx) begin
                        if (pidx == JC_W'(J - 1)) begin
                            pidx <= '0;
                            if (kidx + 1'b1 == kcnt) begin
                                state <= ST_EMIT;
                                oidx  <= '0;
                            end else begin
                                kidx <= kidx + 1'b1;
                            end
                        end else begin
                            pidx <= pidx + 1'b1;
                        end
                    end
                end
                ST_EMIT: begin
                    if (oidx + 1'b1 >= mcnt) state <= ST_DONE;
                    else                     oidx  <= oidx + 1'b1;
                end
                default: begin
                    state <= ST_COLLECT;
                    fresh <= 1'b1;
                end
            endcase
        end
    end

    assign out_valid = (state == ST_EMIT);
    assign out_code  = fin_items[oidx].code;
    assign out_lag   = fin_items[oidx].lag;
    assign out_mag   = fin_items[oidx].mag;
    assign out_count = mcnt;
    assign done      = (state == ST_DONE);
endmodule

// File: rtl/peak_sel_chk.sv
// Output-protocol checker for peak_sel_top, attached by bind.
module peak_sel_chk #(
    parameter int M     = 12,
    parameter int MAG_W = 12,
    localparam int MC_W = $clog2(M + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic [MAG_W-1:0] out_mag,
    input logic [MC_W-1:0]  out_count,
    input logic             done
);
    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done and an entry never share a cycle
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));

    // R7: consecutive entries never rise in magnitude
    p_desc_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_mag <= $past(out_mag));

    // R6: reported count stays within M and is non-zero
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_count <= MC_W'(M) && out_count != '0));

    // R7: the last entry is followed by done
    p_done_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> done);
endmodule

bind peak_sel_top peak_sel_chk #(.M(M), .MAG_W(peak_sel_pkg::MAG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_mag(out_mag),
    .out_count(out_count), .done(done)
);

// File: tb/peak_sel_top_tb_top.sv
`timescale 1ns/1ps
module peak_sel_top_tb_top;
    localparam int K = 4, J = 3, M = 6;
    localparam int NC = 64, NL = 32;
    localparam int MC_W = $clog2(M + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [5:0]      in_code = '0;
    logic [4:0]      in_lag = '0;
    logic [11:0]     in_mag = '0;
    logic            in_last = 1'b0;
    logic            in_final = 1'b0;
    logic            out_valid;
    logic [5:0]      out_code;
    logic [4:0]      out_lag;
    logic [11:0]     out_mag;
    logic [MC_W-1:0] out_count;
    logic            done;

    int mags [NC][NL];
    int e_code[64], e_lag[64], e_mag[64], e_n;
    int g_code[64], g_lag[64], g_mag[64], g_n, g_cnt;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    peak_sel_top #(.K(K), .J(J), .M(M)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    function automatic bit above(int am, int ac, int al, int bm, int bc, int bl);
        if (am != bm) return am > bm;
        if (ac != bc) return ac < bc;
        return al < bl;
    endfunction

    // Expected result built from the requirements alone
    task automatic build_expected();
        int cmax[NC];
        bit used[NC];
        int kept[K];
        int pc[64], pl[64], pm[64];
        bit taken[64];
        int pn;
        for (int c = 0; c < NC; c++) begin
            cmax[c] = mags[c][0];
            used[c] = 1'b0;
            for (int l = 1; l < NL; l++) if (mags[c][l] > cmax[c]) cmax[c] = mags[c][l];
        end
        for (int k = 0; k < K; k++) begin
            int best = -1;
            for (int c = 0; c < NC; c++)
                if (!used[c] && (best < 0 || cmax[c] > cmax[best])) best = c;
            used[best] = 1'b1;
            kept[k] = best;
        end
        pn = 0;
        for (int k = 0; k < K; k++) begin
            int ch[J];
            int nch = 0;
            for (int p = 0; p < J; p++) begin
                int bl = -1;
                for (int l = 0; l < NL; l++) begin
                    bit ex = 1'b0;
                    for (int q = 0; q < nch; q++)
                        if ((l > ch[q] ? l - ch[q] : ch[q] - l) <= 2) ex = 1'b1;
                    if (!ex && (bl < 0 || mags[kept[k]][l] > mags[kept[k]][bl])) bl = l;
                end
                if (bl >= 0) begin
                    ch[nch] = bl;
                    nch++;
                    pc[pn] = kept[k]; pl[pn] = bl; pm[pn] = mags[kept[k]][bl];
                    taken[pn] = 1'b0;
                    pn++;
                end
            end
        end
        e_n = (pn < M) ? pn : M;
        for (int e = 0; e < e_n; e++) begin
            int bi = -1;
            for (int i = 0; i < pn; i++)
                if (!taken[i] && (bi < 0 || above(pm[i], pc[i], pl[i], pm[bi], pc[bi], pl[bi])))
                    bi = i;
            taken[bi] = 1'b1;
            e_code[e] = pc[bi]; e_lag[e] = pl[bi]; e_mag[e] = pm[bi];
        end
    endtask

    // Stream one batch, gather the results and compare them
    task automatic run_batch(input bit descending, input string tag);
        build_expected();
        for (int ci = 0; ci < NC; ci++) begin
            int c = descending ? NC - 1 - ci : ci;
            for (int l = 0; l < NL; l++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_code  = 6'(c);
                in_lag   = 5'(l);
                in_mag   = 12'(mags[c][l]);
                in_last  = (l == NL - 1);
                in_final = (l == NL - 1) && (ci == NC - 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_final = 1'b0;
        g_n = 0;
        g_cnt = -1;
        forever begin
            if (out_valid && g_n < 64) begin
                g_code[g_n] = int'(out_code);
                g_lag[g_n]  = int'(out_lag);
                g_mag[g_n]  = int'(out_mag);
                g_n++;
            end
            if (done) begin
                g_cnt = int'(out_count);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done, "R8 done width", $sformatf("done=%0b", done), "done=0");
        chk(g_n == e_n, "R7 entries", $sformatf("%0d", g_n), $sformatf("%0d", e_n));
        chk(g_cnt == e_n, "R6 count", $sformatf("%0d", g_cnt), $sformatf("%0d", e_n));
        for (int i = 0; i < e_n; i++) begin
            chk(g_code[i] == e_code[i] && g_lag[i] == e_lag[i] && g_mag[i] == e_mag[i],
                $sformatf("%s entry %0d", tag, i),
                $sformatf("c%0d l%0d m%0d", g_code[i], g_lag[i], g_mag[i]),
                $sformatf("c%0d l%0d m%0d", e_code[i], e_lag[i], e_mag[i]));
        end
    endtask

    task automatic fill_random(input int hi);
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++) mags[c][l] = int'($urandom_range(hi, 0));
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R7 watchdog: actual no done expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!out_valid && !done, "R1 in reset", $sformatf("v=%0b d=%0b", out_valid, done), "v=0 d=0");
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done, "R1 after reset", $sformatf("v=%0b d=%0b", out_valid, done), "v=0 d=0");

        // R2: plain random batch
        fill_random(4095);
        run_batch(1'b0, "R2");

        // R3: equal code maxima, streamed in descending code order
        fill_random(1000);
        mags[60][7] = 3000; mags[40][20] = 3000; mags[9][3] = 3000; mags[5][30] = 3000;
        run_batch(1'b1, "R3");

        // R4: all zero, every comparison ties
        fill_random(0);
        run_batch(1'b0, "R4");

        // R5: clustered peak probing exclusion distances 2 and 3
        fill_random(100);
        mags[2][10] = 2000; mags[2][11] = 2001; mags[2][12] = 2002;
        mags[2][13] = 2001; mags[2][14] = 2000; mags[2][9] = 1950; mags[2][15] = 1900;
        run_batch(1'b0, "R5");

        // R6: narrow range, dense ties across codes and lags
        fill_random(3);
        run_batch(1'b0, "R6");

        // R9: fresh batch after earlier ones
        fill_random(2047);
        run_batch(1'b1, "R9");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule